// File: doc/BRIEF.md
# Five-Stage Pipeline Interlock Controller

This block is the control path of an in-order instruction pipeline whose five stages are fetch, decode, operand fetch, execute and write-back. Each stage holds a slot made of a valid bit, a branch flag, a destination register tag and two source register tags. The datapath, memory and register file values are outside the block, and the register tags stand in for them. A fetch-side handshake delivers instruction descriptors. A single mispredict input comes from the branch resolution logic in the execute stage.

The controller has no forwarding paths. A read-after-write conflict holds the consumer in operand fetch until the producer has left write-back. While it is held, the slots behind it freeze and empty slots (bubbles) flow into execute. Every branch is predicted taken. When a branch in execute turns out to be mispredicted, the controller discards the younger work in the three front stages. Two free-running counters, one for cycles and one for retired instructions, let a test environment compare throughput against a model.

Top module: `pipe_interlock_ctrl`

## Requirements
- R1: While reset is held and after it is released, every stage is empty (`stage_valid` = 0). `in_ready` is 1, and both counters read 0.
- R2: A descriptor is accepted at a clock edge where `in_valid` and `in_ready` are both 1. With no conflict, its destination tag appears on `retire_dst` with `retire_valid` high four edges after the accepting edge. Back-to-back accepted descriptors retire one per cycle in acceptance order.
- R3: The slot in operand fetch is held while a valid slot in execute or write-back has a destination tag equal to one of its source tags. A consumer accepted right after its producer retires two cycles later than R2 gives. A consumer accepted two after its producer retires one cycle later than R2 gives. A consumer three or more behind is not delayed.
- R4: During a hold, `in_ready` is 0 and fetch and decode keep their contents. Execute receives a bubble and write-back keeps advancing. The `stage_valid` bit order is fetch at bit 0 through write-back at bit 4.
- R5: Pairs that only share a source tag, pairs that share a destination tag, and pairs where the younger writes a register the older reads never delay retirement.
- R6: Tag value 0 means no register and never creates a conflict, either as a source or as a destination.
- R7: A mispredict signalled while execute holds a valid branch empties fetch, decode and operand fetch at the next edge, and execute receives a bubble. The descriptor presented in that cycle is dropped. Discarded instructions never retire. The branch itself retires.
- R8: When a hold and a mispredict arise in the same cycle, the mispredict wins. The held consumer is discarded and `in_ready` returns to 1 in the next cycle.
- R9: A mispredict signalled while execute does not hold a valid branch has no effect, and the in-flight instructions retire on time.
- R10: `cycle_count` increments at every edge out of reset. `retire_count` increments once for every cycle in which `retire_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Fetch side offers a descriptor |
| in_dst | input | TAG_W | Destination register tag (0 = none) |
| in_src0 | input | TAG_W | First source register tag (0 = none) |
| in_src1 | input | TAG_W | Second source register tag (0 = none) |
| in_branch | input | 1 | Descriptor is a conditional branch |
| in_ready | output | 1 | Fetch stage can take a descriptor this cycle |
| res_mispredict | input | 1 | Branch in execute was mispredicted |
| stage_valid | output | 5 | Valid bits, bit 0 fetch through bit 4 write-back |
| retire_valid | output | 1 | Write-back holds an instruction this cycle |
| retire_dst | output | TAG_W | Destination tag of the retiring instruction |
| cycle_count | output | CNT_W | Cycles since reset |
| retire_count | output | CNT_W | Instructions retired since reset |

## Verification
For every descriptor it accepts, the driver records the edge at which it was accepted. It then queues the destination tag together with a due cycle: that edge plus four, plus the bubbles that R3 predicts for the scenario. The monitor compares each retirement against the head of the queue at the falling edge of exactly that cycle, and treats any retirement of a discarded instruction as a miscompare. Checks on hold and flush read `in_ready` and `stage_valid` at the falling edge of the specific cycle counted from the acceptance edges: one edge after the mispredict, and the third and fourth cycles after the producer enters fetch during a hold.

// File: rtl/pil_pkg.sv
package pil_pkg;
  localparam int TAG_W  = 5;
  localparam int NSTAGE = 5;
  localparam int IF_S   = 0;
  localparam int ID_S   = 1;
  localparam int OF_S   = 2;
  localparam int EX_S   = 3;
  localparam int WB_S   = 4;
  localparam int NOLDER = NSTAGE - 1 - OF_S;

  typedef logic [TAG_W-1:0] tag_t;

  typedef struct packed {
    logic vld;
    logic br;
    tag_t dst;
    tag_t s0;
    tag_t s1;
  } slot_t;

  function automatic logic tag_hit(tag_t src, tag_t dst);
    return (src != '0) && (src == dst);
  endfunction
endpackage

// File: rtl/pil_stage_reg.sv
module pil_stage_reg
  import pil_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  hold,
  input  logic  kill,
  input  slot_t d,
  output slot_t q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (kill) begin
      q.vld <= 1'b0;
    end else if (!hold) begin
      q <= d;
    end
  end
endmodule

// File: rtl/pil_hazard_unit.sv
module pil_hazard_unit
  import pil_pkg::*;
(
  input  slot_t of_slot,
  input  slot_t older [NOLDER],
  output logic  raw_hit
);
  logic [NOLDER-1:0] hit_v;

  for (genvar j = 0; j < NOLDER; j++) begin : g_cmp
    assign hit_v[j] = older[j].vld &&
                      (tag_hit(of_slot.s0, older[j].dst) ||
                       tag_hit(of_slot.s1, older[j].dst));
  end

  assign raw_hit = of_slot.vld && (|hit_v);
endmodule

// File: rtl/pil_perf_cnt.sv
module pil_perf_cnt #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             retire,
  output logic [CNT_W-1:0] cycles,
  output logic [CNT_W-1:0] retired
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cycles  <= '0;
      retired <= '0;
    end else begin
      cycles <= cycles + 1'b1;
      if (retire) retired <= retired + 1'b1;
    end
  end
endmodule

// File: rtl/pipe_interlock_ctrl.sv
module pipe_interlock_ctrl
  import pil_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [TAG_W-1:0]  in_dst,
  input  logic [TAG_W-1:0]  in_src0,
  input  logic [TAG_W-1:0]  in_src1,
  input  logic              in_branch,
  output logic              in_ready,
  input  logic              res_mispredict,
  output logic [NSTAGE-1:0] stage_valid,
  output logic              retire_valid,
  output logic [TAG_W-1:0]  retire_dst,
  output logic [CNT_W-1:0]  cycle_count,
  output logic [CNT_W-1:0]  retire_count
);
  slot_t st_q    [NSTAGE];
  slot_t stage_d [NSTAGE];
  slot_t older   [NOLDER];
  slot_t fetch_slot;
  logic  stall;
  logic  flush;
  logic  ex_is_branch;
  logic [NSTAGE-1:0] hold_v;
  logic [NSTAGE-1:0] kill_v;

  assign in_ready = ~stall;

  always_comb begin
    fetch_slot.vld = in_valid & in_ready;
    fetch_slot.br  = in_branch;
    fetch_slot.dst = in_dst;
    fetch_slot.s0  = in_src0;
    fetch_slot.s1  = in_src1;
  end

  assign ex_is_branch = st_q[EX_S].vld & st_q[EX_S].br;
  assign flush        = res_mispredict & ex_is_branch;

  for (genvar j = 0; j < NOLDER; j++) begin : g_older
    assign older[j] = st_q[OF_S+1+j];
  end

  pil_hazard_unit u_haz (
    .of_slot (st_q[OF_S]),
    .older   (older),
    .raw_hit (stall)
  );

  for (genvar i = 0; i < NSTAGE; i++) begin : g_stage
    if (i == 0) begin : g_head
      assign stage_d[i] = fetch_slot;
    end else begin : g_body
      assign stage_d[i] = st_q[i-1];
    end
    assign hold_v[i] = stall & ~flush & (i <= OF_S);
    assign kill_v[i] = (flush & (i <= EX_S)) | (stall & (i == EX_S));

    pil_stage_reg u_reg (
      .clk  (clk),
      .rst  (rst),
      .hold (hold_v[i]),
      .kill (kill_v[i]),
      .d    (stage_d[i]),
      .q    (st_q[i])
    );

    assign stage_valid[i] = st_q[i].vld;
  end

  assign retire_valid = st_q[WB_S].vld;
  assign retire_dst   = st_q[WB_S].dst;

  pil_perf_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .retire  (retire_valid),
    .cycles  (cycle_count),
    .retired (retire_count)
  );
endmodule

// File: rtl/pil_checker.sv
module pil_checker #(
  parameter int CNT_W = 32,
  parameter int NST   = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             in_ready,
  input logic             res_mispredict,
  input logic             ex_is_branch,
  input logic [NST-1:0]   stage_valid,
  input logic             retire_valid,
  input logic [CNT_W-1:0] cycle_count,
  input logic [CNT_W-1:0] retire_count
);
  AST_RESET_EMPTY: assert property (@(posedge clk)
    rst |=> (stage_valid == '0 && retire_count == '0 && cycle_count == '0)); // R1

  AST_HOLD_FRONT: assert property (@(posedge clk) disable iff (rst)
    (!in_ready && !res_mispredict) |=> stage_valid[1:0] == $past(stage_valid[1:0])); // R4

  AST_HOLD_BUBBLE: assert property (@(posedge clk) disable iff (rst)
    !in_ready |=> !stage_valid[3]); // R3

  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (res_mispredict && ex_is_branch) |=> (stage_valid[3:0] == '0 && in_ready)); // R7

  AST_FLUSH_RETIRES_BRANCH: assert property (@(posedge clk) disable iff (rst)
    (res_mispredict && ex_is_branch) |=> retire_valid); // R8

  AST_RETIRE_COUNT: assert property (@(posedge clk) disable iff (rst)
    retire_valid |=> retire_count == $past(retire_count) + 1'b1); // R10

  AST_CYCLE_COUNT: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> cycle_count == $past(cycle_count) + 1'b1); // R10
endmodule

bind pipe_interlock_ctrl pil_checker #(.CNT_W(CNT_W), .NST(pil_pkg::NSTAGE)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .in_ready       (in_ready),
  .res_mispredict (res_mispredict),
  .ex_is_branch   (ex_is_branch),
  .stage_valid    (stage_valid),
  .retire_valid   (retire_valid),
  .cycle_count    (cycle_count),
  .retire_count   (retire_count)
);

// File: tb/pipe_interlock_ctrl_tb.sv
module pipe_interlock_ctrl_tb;
  localparam int TW = 5;
  localparam int CW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [TW-1:0] in_dst = '0, in_src0 = '0, in_src1 = '0;
  logic          in_branch = 1'b0;
  logic          in_ready;
  logic          res_mispredict = 1'b0;
  logic [4:0]    stage_valid;
  logic          retire_valid;
  logic [TW-1:0] retire_dst;
  logic [CW-1:0] cycle_count, retire_count;

  int n_chk = 0, n_fail = 0, cyc = 0, ret_seen = 0;

  typedef struct { int dst; int due; string req; } exp_t;
  exp_t sbq[$];

  always #5 clk = ~clk;

  pipe_interlock_ctrl u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_dst(in_dst),
    .in_src0(in_src0), .in_src1(in_src1), .in_branch(in_branch),
    .in_ready(in_ready), .res_mispredict(res_mispredict),
    .stage_valid(stage_valid), .retire_valid(retire_valid),
    .retire_dst(retire_dst), .cycle_count(cycle_count),
    .retire_count(retire_count)
  );

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  task automatic chk(input string req, input string what,
                     input longint act, input longint exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp_v);
    end
  endtask

  // Monitor: every retirement must match the queue head in tag and cycle.
  always @(negedge clk) begin
    if (!rst && retire_valid) begin
      ret_seen++;
      if (sbq.size() == 0) begin
        chk("R7", "unexpected retirement tag", retire_dst, -1);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        chk(e.req, "retire tag", retire_dst, e.dst);
        chk(e.req, "retire cycle", cyc, e.due);
      end
    end
  end

  // Driver: extra < 0 marks an instruction expected to be discarded.
  task automatic issue(input int d, input int s0, input int s1, input bit br,
                       input int extra, input string req, output int acc);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid  = 1'b1;
    in_dst    = TW'(d);
    in_src0   = TW'(s0);
    in_src1   = TW'(s1);
    in_branch = br;
    acc = cyc + 1;
    if (extra >= 0) sbq.push_back('{dst: d, due: acc + 4 + extra, req: req});
    @(posedge clk);
    #1 in_valid = 1'b0;
    in_branch = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    do @(negedge clk); while (cyc < n);
  endtask

  task automatic drain(input string req);
    repeat (12) @(negedge clk);
    chk(req, "scoreboard empty after drain", sbq.size(), 0);
  endtask

  initial begin
    #2_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int a, b, c, t;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "stage_valid in reset", stage_valid, 0);
    chk("R1", "in_ready in reset", in_ready, 1);
    chk("R1", "retire_count in reset", retire_count, 0);
    chk("R1", "cycle_count in reset", cycle_count, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "stage_valid after reset", stage_valid, 0);

    // R2: six independent back-to-back descriptors
    for (int k = 0; k < 6; k++) issue(11 + k, 1, 2, 1'b0, 0, "R2", a);
    drain("R2");

    // R3/R4: adjacent RAW via src0, with a trailing independent one
    issue(3, 0, 0, 1'b0, 0, "R3", a);
    issue(20, 3, 0, 1'b0, 2, "R3", b);
    issue(21, 1, 2, 1'b0, 2, "R4", c);
    wait_cyc(a + 3);
    chk("R4", "in_ready first hold cycle", in_ready, 0);
    chk("R4", "stage_valid first hold cycle", stage_valid, 5'b01110);
    wait_cyc(a + 4);
    chk("R4", "in_ready second hold cycle", in_ready, 0);
    chk("R4", "stage_valid second hold cycle", stage_valid, 5'b10110);
    wait_cyc(a + 5);
    chk("R3", "in_ready after producer left", in_ready, 1);
    drain("R3");

    // R3: adjacent RAW via src1
    issue(4, 0, 0, 1'b0, 0, "R3", a);
    issue(22, 1, 4, 1'b0, 2, "R3", b);
    drain("R3");

    // R3: distance two, one bubble
    issue(8, 0, 0, 1'b0, 0, "R3", a);
    issue(23, 1, 2, 1'b0, 0, "R3", b);
    issue(24, 8, 0, 1'b0, 1, "R3", c);
    drain("R3");

    // R3: distance three, no delay
    issue(10, 0, 0, 1'b0, 0, "R3", a);
    issue(25, 1, 2, 1'b0, 0, "R3", b);
    issue(26, 1, 2, 1'b0, 0, "R3", c);
    issue(27, 10, 0, 1'b0, 0, "R3", t);
    drain("R3");

    // R5: shared source, shared destination, younger writes older's source
    issue(12, 4, 0, 1'b0, 0, "R5", a);
    issue(13, 0, 4, 1'b0, 0, "R5", b);
    issue(6, 1, 2, 1'b0, 0, "R5", c);
    issue(6, 2, 1, 1'b0, 0, "R5", t);
    issue(14, 9, 0, 1'b0, 0, "R5", a);
    issue(9, 1, 0, 1'b0, 0, "R5", b);
    drain("R5");

    // R6: tag 0 as destination and as source
    issue(0, 1, 2, 1'b0, 0, "R6", a);
    issue(15, 0, 0, 1'b0, 0, "R6", b);
    drain("R6");

    // R7: mispredicted branch discards three younger and the presented one
    issue(16, 1, 0, 1'b1, 0, "R7", a);
    issue(17, 0, 0, 1'b0, -1, "R7", b);
    issue(18, 0, 0, 1'b0, -1, "R7", c);
    issue(19, 0, 0, 1'b0, -1, "R7", t);
    @(negedge clk);
    chk("R7", "cycle of mispredict", cyc, a + 3);
    res_mispredict = 1'b1;
    in_valid = 1'b1;
    in_dst = 5'd30;
    @(posedge clk);
    #1 res_mispredict = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);
    chk("R7", "stage_valid after flush", stage_valid, 5'b10000);
    issue(28, 0, 0, 1'b0, 0, "R7", b);
    drain("R7");

    // R8: hold and mispredict in the same cycle
    issue(5, 0, 0, 1'b1, 0, "R8", a);
    issue(29, 5, 0, 1'b0, -1, "R8", b);
    wait_cyc(a + 3);
    chk("R8", "in_ready during hold", in_ready, 0);
    res_mispredict = 1'b1;
    @(posedge clk);
    #1 res_mispredict = 1'b0;
    @(negedge clk);
    chk("R8", "stage_valid after flush over hold", stage_valid, 5'b10000);
    chk("R8", "in_ready after flush over hold", in_ready, 1);
    drain("R8");

    // R9: mispredict while execute holds a non-branch
    issue(7, 0, 0, 1'b0, 0, "R9", a);
    issue(31, 0, 0, 1'b0, 0, "R9", b);
    wait_cyc(a + 3);
    res_mispredict = 1'b1;
    @(posedge clk);
    #1 res_mispredict = 1'b0;
    @(negedge clk);
    chk("R9", "stage_valid after ignored mispredict", stage_valid, 5'b11000);
    drain("R9");

    // R10: counters
    @(negedge clk);
    chk("R10", "cycle_count", cycle_count, cyc);
    chk("R10", "retire_count", retire_count, ret_seen);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule